// File: doc/BRIEF.md
# I2C Register-Port Slave with Group Addressing

This block is an I2C target that gives a bus host read and write access to a bank of 128 eight-bit registers. It oversamples SCL and SDA with the system clock and pulls SDA low through an open-drain output enable. It takes received bits on SCL rising edges and changes SDA only while SCL is low.

The block answers to three 7-bit chip addresses: an individual address and two group addresses. Writes are accepted through any of the three. Reads are accepted only through the individual address. A read request sent to any other address puts the block into a dormant state. It stays dormant until it sees a STOP, and it then responds again at the next START.

After the chip address, a write carries a pointer byte. Its low seven bits pick a register and its top bit turns on auto-increment. The three chip addresses are held in the top three register slots, so the host can rewrite them over the bus. Their reset value is binary 100000 followed by a strap pin, which is sampled as reset is released.

Top module: `regport_i2c_slave`

## Requirements
- R1: While and right after reset, `sda_oe` is 0. The registers at pointers 125, 126 and 127 read back 0x40 plus the level of `addr_strap` held in the last reset cycle. Every other register reads 0x00.
- R2: When the address byte holds the individual address with direction bit 0 (bit 0 of the byte, sent last), the slave pulls SDA low in the acknowledge slot of the address byte, the pointer byte and every data byte. Each data byte is stored at the current pointer.
- R3: A write addressed to the group-1 address (pointer 126, bits 6:0) or to the group-2 address (pointer 127, bits 6:0) is acknowledged and stored in the same way as R2.
- R4: An address byte that matches none of the three addresses gets no acknowledge, and SDA stays released for the rest of the transfer.
- R5: In a read addressed to the individual address with direction bit 1, the slave acknowledges the address. It then shifts out the register at the current pointer, most significant bit first, one bit per SCL clock.
- R6: A read request to any address other than the individual address gets no acknowledge. After it, every START, address and data byte is ignored, and no data is stored, until a STOP has been seen. The next START is then handled normally.
- R7: When bit 7 of the pointer byte is 1, the pointer moves up by one after each data byte, on both writes and reads, and wraps from 127 to 0. When bit 7 is 0, the pointer stays the same for every byte.
- R8: Writing to pointer 125, 126 or 127 changes the individual, group-1 or group-2 address respectively. Later address bytes are matched against the new value.
- R9: A NACK from the master after a read byte ends the read. SDA stays released through any further SCL clocks until the next START or STOP.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_strap | input | 1 | Strap that supplies the LSB of all three addresses at reset release |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Register data is written with patterns that alternate 1s and 0s, so a byte shifted out in the wrong bit order or with an off-by-one bit position reads back as a different value. Writes and reads run with auto-increment on and off and across the 127-to-0 boundary, which separates a pointer that advances, a pointer that stays fixed and a pointer that wraps. The same bytes are sent to the individual address, to each group address, to an address that matches nothing and to a group address with the read bit set. This shows whether the acknowledge and dormant behaviour depends on the address and the direction bit. A read ended by a NACK and followed by more SCL clocks shows whether the slave keeps driving the line after the master has ended the read.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int DATA_W    = 8;
    localparam int PTR_W     = 7;
    localparam int DEV_W     = 7;
    localparam int SYNC_LEN  = 2;
    localparam logic [5:0] DEV_HI_DEFAULT = 6'b100000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    // The top three slots hold individual, group-1 and group-2 addresses.
    function automatic logic [DATA_W-1:0] slot_reset(input int idx, input int nregs,
                                                     input logic strap);
        if (idx >= nregs - 3)
            return {1'b0, DEV_HI_DEFAULT, strap};
        return '0;
    endfunction

endpackage

// File: rtl/i2cp_busmon.sv
module i2cp_busmon
    import i2cp_pkg::*;
#(
    parameter int STAGES = SYNC_LEN
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_s,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/i2cp_regbank.sv
module i2cp_regbank
    import i2cp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_ptr,
    output logic [DW-1:0] rd_data,
    output logic [DEV_W-1:0] dev_ind,
    output logic [DEV_W-1:0] dev_g1,
    output logic [DEV_W-1:0] dev_g2
);
    localparam int NREGS = 1 << PW;
    localparam int SLOT_IND = NREGS - 3;
    localparam int SLOT_G1  = NREGS - 2;
    localparam int SLOT_G2  = NREGS - 1;

    logic [DW-1:0] mem [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++)
                mem[i] <= DW'(slot_reset(i, NREGS, strap));
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];
    assign dev_ind = mem[SLOT_IND][DEV_W-1:0];
    assign dev_g1  = mem[SLOT_G1][DEV_W-1:0];
    assign dev_g2  = mem[SLOT_G2][DEV_W-1:0];

endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine
    import i2cp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic             scl_s,
    input  logic [DEV_W-1:0] dev_ind,
    input  logic [DEV_W-1:0] dev_g1,
    input  logic [DEV_W-1:0] dev_g2,
    input  logic [DW-1:0]    rd_data,
    output logic [PW-1:0]    ptr,
    output logic             wr_en,
    output logic [PW-1:0]    wr_ptr,
    output logic [DW-1:0]    wr_data,
    output logic             sda_oe
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);

    eng_state_t    state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh, tx;
    logic          inc, rd_dir, dormant, mack;

    logic [DEV_W-1:0] rx_dev;
    logic             rx_rd, hit_ind, hit_any;

    assign rx_dev  = sh[DW-1:1];
    assign rx_rd   = sh[0];
    assign hit_ind = (rx_dev == dev_ind);
    assign hit_any = hit_ind || (rx_dev == dev_g1) || (rx_dev == dev_g2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            ptr     <= '0;
            inc     <= 1'b0;
            rd_dir  <= 1'b0;
            dormant <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.stop) begin
                state   <= ST_IDLE;
                dormant <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (ev.start && !dormant) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (!dormant) begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (ev.rise && cnt != FULL) begin
                            sh  <= {sh[DW-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (rx_rd) begin
                                    if (hit_ind) begin
                                        sda_oe <= 1'b1;
                                        rd_dir <= 1'b1;
                                        state  <= ST_ADDR_ACK;
                                    end else begin
                                        dormant <= 1'b1;
                                        state   <= ST_IDLE;
                                    end
                                end else if (hit_any) begin
                                    sda_oe <= 1'b1;
                                    rd_dir <= 1'b0;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr    <= sh[PW-1:0];
                                inc    <= sh[DW-1];
                                sda_oe <= 1'b1;
                                state  <= ST_PTR_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_ptr  <= ptr;
                                wr_data <= sh;
                                if (inc) ptr <= ptr + 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            if (rd_dir) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                cnt    <= CW'(1);
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[DW-2];
                                tx     <= {tx[DW-2:0], 1'b0};
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            mack <= ~ev.sda;
                            if (inc) ptr <= ptr + 1'b1;
                        end else if (ev.fall) begin
                            if (mack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                cnt    <= CW'(1);
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    p_reset_release_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sda_oe);

    p_write_ack_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> sda_oe);

    p_dormant_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        dormant |-> (!sda_oe && !wr_en));

    p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK && ev.rise && inc && ptr == '1 && !ev.start && !ev.stop && !dormant)
        |=> ptr == '0);

    p_idle_release_r9: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> !sda_oe);

    p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) && !$past(ev.start || ev.stop) |-> !scl_s);

endmodule

// File: rtl/regport_i2c_slave.sv
module regport_i2c_slave
    import i2cp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PTR_W
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_strap,
    output logic sda_oe
);
    bus_ev_t          ev;
    logic             scl_s;
    logic [PW-1:0]    ptr, wr_ptr;
    logic [DW-1:0]    rd_data, wr_data;
    logic             wr_en;
    logic [DEV_W-1:0] dev_ind, dev_g1, dev_g2;

    i2cp_busmon #(.STAGES(SYNC_LEN)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .ev    (ev)
    );

    i2cp_regbank #(.DW(DW), .PW(PW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .strap   (addr_strap),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_ptr  (ptr),
        .rd_data (rd_data),
        .dev_ind (dev_ind),
        .dev_g1  (dev_g1),
        .dev_g2  (dev_g2)
    );

    i2cp_engine #(.DW(DW), .PW(PW)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .scl_s   (scl_s),
        .dev_ind (dev_ind),
        .dev_g1  (dev_g1),
        .dev_g2  (dev_g2),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

endmodule

// File: tb/sim_regport_i2c_slave.sv
module sim_regport_i2c_slave;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic strap = 1'b1;
    logic sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    typedef struct {
        string tag;
        int    val;
    } item_t;

    item_t exp_q[$];
    int    got_q[$];
    item_t e_cur;
    int    g_cur;
    int    checks = 0;
    int    bad = 0;
    int    viol = 0;
    logic  prev_oe = 1'b0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    regport_i2c_slave u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .addr_strap (strap),
        .sda_oe     (sda_oe)
    );

    // Scoreboard monitor: pairs observed values with queued expectations.
    always @(negedge clk) begin
        while (got_q.size() > 0 && exp_q.size() > 0) begin
            e_cur = exp_q.pop_front();
            g_cur = got_q.pop_front();
            checks++;
            if (g_cur != e_cur.val) begin
                bad++;
                $display("FAIL %s got=%0h exp=%0h", e_cur.tag, g_cur, e_cur.val);
            end
        end
    end

    // R10 bench monitor: sda_oe must not change while raw SCL is high.
    always @(posedge clk) begin
        if (!rst && sda_oe !== prev_oe && m_scl) viol++;
        prev_oe <= sda_oe;
    end

    task automatic expect_v(input string tag, input int v);
        item_t it;
        it.tag = tag;
        it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic observe(input int v);
        got_q.push_back(v);
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output int ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = (b == 1'b0) ? 1 : 0;
    endtask

    task automatic recv_byte(output int v, input bit give_ack);
        logic [7:0] r;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            r[i] = b;
        end
        send_bit(give_ack ? 1'b0 : 1'b1);
        v = int'(r);
    endtask

    task automatic write_txn(input logic [6:0] dev, input logic [7:0] ptrb, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                             input int addr_ack, input string tag);
        logic [7:0] d [3];
        int a;
        d[0] = d0; d[1] = d1; d[2] = d2;
        i2c_start();
        expect_v(tag, addr_ack);
        send_byte({dev, 1'b0}, a);
        observe(a);
        if (a == 1) begin
            expect_v(tag, 1);
            send_byte(ptrb, a);
            observe(a);
            for (int i = 0; i < n; i++) begin
                expect_v(tag, 1);
                send_byte(d[i], a);
                observe(a);
            end
        end
        i2c_stop();
    endtask

    task automatic read_txn(input logic [6:0] dev, input int n,
                            input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                            input string tag);
        logic [7:0] e [3];
        int a, v;
        e[0] = e0; e[1] = e1; e[2] = e2;
        i2c_start();
        expect_v(tag, 1);
        send_byte({dev, 1'b1}, a);
        observe(a);
        if (a == 1) begin
            for (int i = 0; i < n; i++) begin
                expect_v(tag, int'(e[i]));
                recv_byte(v, i != n - 1);
                observe(v);
            end
        end
        i2c_stop();
    endtask

    task automatic set_ptr(input logic [6:0] dev, input logic [7:0] ptrb, input string tag);
        write_txn(dev, ptrb, 0, 8'h00, 8'h00, 8'h00, 1, tag);
    endtask

    task automatic do_reset(input logic s);
        rst = 1'b1;
        strap = s;
        m_scl = 1'b1;
        m_sda = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        strap = ~s;
        repeat (4) @(negedge clk);
        expect_v("R1", 0);
        observe(int'(sda_oe));
    endtask

    initial begin
        int a, v;

        // R1: reset with strap high, address slots read 0x41.
        do_reset(1'b1);
        set_ptr(7'h41, 8'hFD, "R1");
        read_txn(7'h41, 3, 8'h41, 8'h41, 8'h41, "R1");

        // R2 / R5: auto-increment write then read back, MSB first.
        write_txn(7'h41, 8'h85, 3, 8'hA5, 8'h5A, 8'h3C, 1, "R2");
        set_ptr(7'h41, 8'h85, "R5");
        read_txn(7'h41, 3, 8'hA5, 8'h5A, 8'h3C, "R5");

        // R7: fixed pointer write, then inc and fixed reads.
        write_txn(7'h41, 8'h10, 3, 8'h11, 8'h22, 8'h33, 1, "R7");
        set_ptr(7'h41, 8'h90, "R7");
        read_txn(7'h41, 2, 8'h33, 8'h00, 8'h00, "R7");
        set_ptr(7'h41, 8'h10, "R7");
        read_txn(7'h41, 2, 8'h33, 8'h33, 8'h00, "R7");

        // R7 / R8: write across 127 -> 0, which also sets group-2 to 0x31.
        write_txn(7'h41, 8'hFF, 2, 8'h31, 8'h99, 8'h00, 1, "R7");
        set_ptr(7'h41, 8'hFF, "R7");
        read_txn(7'h41, 2, 8'h31, 8'h99, 8'h00, "R7");

        // R8 / R3: group-1 to 0x30, then write through both group addresses.
        write_txn(7'h41, 8'h7E, 1, 8'h30, 8'h00, 8'h00, 1, "R8");
        write_txn(7'h30, 8'h20, 1, 8'h5C, 8'h00, 8'h00, 1, "R3");
        write_txn(7'h31, 8'h21, 1, 8'hE7, 8'h00, 8'h00, 1, "R3");
        set_ptr(7'h41, 8'hA0, "R3");
        read_txn(7'h41, 2, 8'h5C, 8'hE7, 8'h00, "R3");

        // R4: address matching nothing is not acknowledged.
        write_txn(7'h22, 8'h00, 0, 8'h00, 8'h00, 8'h00, 0, "R4");

        // R6: read through a group address puts the slave to sleep.
        i2c_start();
        expect_v("R6", 0);
        send_byte({7'h30, 1'b1}, a);
        observe(a);
        i2c_start();
        expect_v("R6", 0);
        send_byte({7'h41, 1'b0}, a);
        observe(a);
        expect_v("R6", 0);
        send_byte(8'h40, a);
        observe(a);
        expect_v("R6", 0);
        send_byte(8'h77, a);
        observe(a);
        i2c_stop();
        set_ptr(7'h41, 8'h40, "R6");
        read_txn(7'h41, 1, 8'h00, 8'h00, 8'h00, "R6");

        // R9: NACK ends the read; later clocks see a released line.
        set_ptr(7'h41, 8'h85, "R9");
        i2c_start();
        expect_v("R9", 1);
        send_byte({7'h41, 1'b1}, a);
        observe(a);
        expect_v("R9", 8'hA5);
        recv_byte(v, 1'b1);
        observe(v);
        expect_v("R9", 8'h5A);
        recv_byte(v, 1'b0);
        observe(v);
        expect_v("R9", 8'hFF);
        recv_byte(v, 1'b0);
        observe(v);
        i2c_stop();

        // R8: move the individual address to 0x12.
        write_txn(7'h41, 8'h7D, 1, 8'h12, 8'h00, 8'h00, 1, "R8");
        write_txn(7'h41, 8'h50, 1, 8'hAB, 8'h00, 8'h00, 0, "R8");
        write_txn(7'h12, 8'h50, 1, 8'hAB, 8'h00, 8'h00, 1, "R8");
        set_ptr(7'h12, 8'h50, "R8");
        read_txn(7'h12, 1, 8'hAB, 8'h00, 8'h00, "R8");

        // R1: reset with strap low; addresses become 0x40 and data clears.
        do_reset(1'b0);
        set_ptr(7'h40, 8'hFD, "R1");
        read_txn(7'h40, 3, 8'h40, 8'h40, 8'h40, "R1");
        set_ptr(7'h40, 8'h85, "R1");
        read_txn(7'h40, 1, 8'h00, 8'h00, 8'h00, "R1");

        // R10: no SDA change while SCL was high.
        expect_v("R10", 0);
        observe(viol);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            bad += exp_q.size();
            $display("FAIL R0 unmatched expectations got=%0d exp=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule